// File: doc/BRIEF.md
# Pointer-Based Memory Address Unit

This unit forms the memory side of a small dual-stack processor. It holds one pointer register and chooses, every cycle, whether the program counter or that pointer goes onto the single word-addressed memory bus. The same bus serves instruction fetch and data traffic. Data access happens only through the pointer, which can optionally step forward by one word after the access. Because of this post-increment, block copies and table walks need no separate address arithmetic.

Each cycle the unit takes an already-decoded memory operation, the current top-of-stack value and the program counter. It returns a bus address, write data and a write strobe. It also returns a value, with a valid flag, for the stack logic to push onto the top of stack, and a flag that tells the program counter to skip an inline literal. Reads are combinational from the bus. Writes and pointer updates take effect at the next rising clock edge.

Top module: `mem_addr_unit`

## Requirements
- R1: After an active-low reset the pointer holds zero, so a copy-pointer operation issued first pushes 0.
- R2: The operation code is 3 bits: 0 idle, 1 load, 2 load-and-step, 3 literal, 4 store, 5 store-and-step, 6 copy-pointer, 7 set-pointer. For codes 0, 3, 6 and 7 the bus address equals the program counter, and for codes 0, 6 and 7 the write strobe is low.
- R3: A load (code 1) drives the pointer onto the address and pushes the read word. It raises no write strobe and leaves the pointer unchanged.
- R4: A load-and-step (code 2) behaves like a load and then adds one to the pointer, modulo 2^ADDR_W.
- R5: A literal (code 3) addresses the program counter, pushes the word read there and raises the PC-advance flag. No other code raises that flag.
- R6: A store (code 4) drives the pointer onto the address, top of stack onto the write data and raises the write strobe. It pushes nothing and leaves the pointer unchanged.
- R7: A store-and-step (code 5) behaves like a store and then adds one to the pointer, wrapping from all-ones to zero.
- R8: A copy-pointer (code 6) pushes the pointer value, zero-extended, and writes nothing to memory.
- R9: A set-pointer (code 7) loads the low ADDR_W bits of top of stack into the pointer. It pushes nothing and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 3 | Decoded memory operation |
| tVal | input | DATA_W | Current top of stack |
| pcVal | input | ADDR_W | Current program counter |
| memRdata | input | DATA_W | Word read from the addressed location |
| memAddr | output | ADDR_W | Word address on the memory bus |
| memWdata | output | DATA_W | Word to write |
| memWe | output | 1 | Write strobe |
| pushEn | output | 1 | Result valid for pushing onto the stack |
| pushData | output | DATA_W | Value to push |
| pcAdvance | output | 1 | Step the program counter past an inline literal |

## Verification
The bench uses the default 32-bit address and data widths. With these widths, setting the pointer to all-ones and issuing a store-and-step shows the wrap to zero at full width. The bench attaches a 4K-word RAM model that decodes the low 12 address bits. Full-width pointer values therefore alias into a small memory, so stepped-store runs can be read back by stepped loads, including across the wrap.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_LOAD    = 3'd1,
    OP_LOADINC = 3'd2,
    OP_LIT     = 3'd3,
    OP_STORE   = 3'd4,
    OP_STOREINC= 3'd5,
    OP_GETPTR  = 3'd6,
    OP_SETPTR  = 3'd7
  } memOp_e;

  typedef struct packed {
    logic selPtr;    // pointer drives the bus address
    logic memWrite;  // raise the write strobe
    logic pushMem;   // push the word read from memory
    logic pushPtr;   // push the pointer value
    logic bumpPtr;   // step the pointer after the access
    logic loadPtr;   // load the pointer from top of stack
    logic pcStep;    // skip the inline literal
  } mauStrobe_t;

endpackage

// File: rtl/mau_ctrl.sv
module mau_ctrl
  import mau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opCode,
  output mauStrobe_t strobe
);

  memOp_e op;
  assign op = memOp_e'(opCode);

  always_comb begin
    strobe = '0;
    unique case (op)
      OP_LOAD:     begin strobe.selPtr = 1'b1; strobe.pushMem = 1'b1; end
      OP_LOADINC:  begin strobe.selPtr = 1'b1; strobe.pushMem = 1'b1; strobe.bumpPtr = 1'b1; end
      OP_LIT:      begin strobe.pushMem = 1'b1; strobe.pcStep = 1'b1; end
      OP_STORE:    begin strobe.selPtr = 1'b1; strobe.memWrite = 1'b1; end
      OP_STOREINC: begin strobe.selPtr = 1'b1; strobe.memWrite = 1'b1; strobe.bumpPtr = 1'b1; end
      OP_GETPTR:   strobe.pushPtr = 1'b1;
      OP_SETPTR:   strobe.loadPtr = 1'b1;
      default:     strobe = '0;
    endcase
  end

  // R8: at most one of write, memory push, pointer push, pointer load per cycle
  assert_one_action_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.memWrite, strobe.pushMem, strobe.pushPtr, strobe.loadPtr}));

  // R6: a write always goes through the pointer
  assert_write_via_ptr_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWrite |-> strobe.selPtr);

  // R5: the PC-advance flag only with a memory push addressed by the PC
  assert_pcstep_lit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pcStep |-> (strobe.pushMem && !strobe.selPtr));

endmodule

// File: rtl/mau_datapath.sv
module mau_datapath
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mauStrobe_t        strobe,
  input  logic [DATA_W-1:0] tVal,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              pushEn,
  output logic [DATA_W-1:0] pushData,
  output logic              pcAdvance
);

  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] xReg;
  logic [DATA_W-1:0] xWide;
  logic [ADDR_W-1:0] tNarrow;

  generate
    if (DATA_W > ADDR_W) begin : g_extend
      assign xWide   = {{(DATA_W-ADDR_W){1'b0}}, xReg};
      assign tNarrow = tVal[ADDR_W-1:0];
    end else begin : g_same
      assign xWide   = xReg[DATA_W-1:0];
      assign tNarrow = tVal[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                xReg <= '0;
    else if (strobe.loadPtr)  xReg <= tNarrow;
    else if (strobe.bumpPtr)  xReg <= xReg + PTR_ONE;
  end

  assign memAddr   = strobe.selPtr ? xReg : pcVal;
  assign memWdata  = tVal;
  assign memWe     = strobe.memWrite;
  assign pushEn    = strobe.pushMem | strobe.pushPtr;
  assign pushData  = strobe.pushPtr ? xWide : memRdata;
  assign pcAdvance = strobe.pcStep;

  // R4 / R7: the pointer steps by exactly one after a stepped access
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bumpPtr && !strobe.loadPtr) |=> xReg == $past(xReg) + PTR_ONE);

  // R9: set-pointer captures top of stack
  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPtr |=> xReg == $past(tNarrow));

  // R3: the pointer holds when neither stepped nor loaded
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.bumpPtr || strobe.loadPtr) |=> $stable(xReg));

  // R2: without a pointer access the bus carries the program counter
  assert_pc_on_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.selPtr |-> memAddr == pcVal);

endmodule

// File: rtl/mem_addr_unit.sv
module mem_addr_unit
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] tVal,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              pushEn,
  output logic [DATA_W-1:0] pushData,
  output logic              pcAdvance
);

  mauStrobe_t strobe;

  mau_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opCode (opCode),
    .strobe (strobe)
  );

  mau_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .tVal      (tVal),
    .pcVal     (pcVal),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memWe     (memWe),
    .pushEn    (pushEn),
    .pushData  (pushData),
    .pcAdvance (pcAdvance)
  );

endmodule

// File: tb/tb_mem_addr_unit.sv
`timescale 1ns/1ps
module tb_mem_addr_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [31:0] tVal = '0;
  logic [31:0] pcVal = '0;
  logic [31:0] memRdata;
  logic [31:0] memAddr, memWdata, pushData;
  logic        memWe, pushEn, pcAdvance;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mem_addr_unit dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .tVal(tVal), .pcVal(pcVal),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .pushEn(pushEn), .pushData(pushData), .pcAdvance(pcAdvance)
  );

  // behavioural 4K-word RAM attached to the bus
  logic [31:0] ram [4096];
  assign memRdata = ram[memAddr[11:0]];
  always @(posedge clk) if (memWe) ram[memAddr[11:0]] <= memWdata;

  // reference model state
  logic [31:0] refX;
  logic [31:0] refMem [4096];

  function automatic string tagOf(input logic [2:0] o);
    case (o)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [31:0] t, input logic [31:0] p,
                      input string tagIn);
    logic [31:0] expAddr, expPush;
    bit isPtr, expWe, expPushEn, expPc;
    string tag;
    tag = (tagIn == "") ? tagOf(o) : tagIn;
    opCode = o; tVal = t; pcVal = p;
    #1;
    isPtr     = (o == 3'd1 || o == 3'd2 || o == 3'd4 || o == 3'd5);
    expAddr   = isPtr ? refX : p;
    expWe     = (o == 3'd4 || o == 3'd5);
    expPushEn = (o == 3'd1 || o == 3'd2 || o == 3'd3 || o == 3'd6);
    expPush   = (o == 3'd6) ? refX : refMem[expAddr[11:0]];
    expPc     = (o == 3'd3);
    chk(memAddr == expAddr, tag, "address", memAddr, expAddr);
    chk(memWe == expWe, tag, "write strobe", 32'(memWe), 32'(expWe));
    chk(pushEn == expPushEn, tag, "push valid", 32'(pushEn), 32'(expPushEn));
    chk(pcAdvance == expPc, tag, "pc advance", 32'(pcAdvance), 32'(expPc));
    if (expWe)     chk(memWdata == t, tag, "write data", memWdata, t);
    if (expPushEn) chk(pushData == expPush, tag, "push data", pushData, expPush);
    @(posedge clk);
    if (expWe) refMem[refX[11:0]] = t;
    if (o == 3'd2 || o == 3'd5) refX = refX + 32'd1;
    if (o == 3'd7) refX = t;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ram[i]    = 32'hA500_0000 ^ (i * 977);
      refMem[i] = 32'hA500_0000 ^ (i * 977);
    end
    refX = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: pointer reads zero right after reset
    step(3'd6, 32'h0, 32'h20, "R1");
    // R2: idle keeps PC on the bus
    step(3'd0, 32'h1234, 32'h40, "");
    // R5: literals fetched at the PC
    step(3'd3, 32'h0, 32'h10, "");
    step(3'd3, 32'h0, 32'h11, "");
    // R9: set pointer, then stepped stores R7
    step(3'd7, 32'd100, 32'h12, "");
    for (int i = 0; i < 4; i++) step(3'd5, 32'd1000 + i, 32'h13, "");
    // R6: plain store at 104, pointer unchanged
    step(3'd4, 32'd55, 32'h14, "");
    step(3'd6, 32'h0, 32'h15, "");
    // round trip: back to 100, stepped loads R4
    step(3'd7, 32'd100, 32'h16, "");
    for (int i = 0; i < 5; i++) step(3'd2, 32'h0, 32'h17, "");
    // R3: plain load twice, pointer holds
    step(3'd1, 32'h0, 32'h18, "");
    step(3'd1, 32'h0, 32'h19, "");
    step(3'd6, 32'h0, 32'h1A, "");
    // R7: wrap from all-ones
    step(3'd7, 32'hFFFF_FFFF, 32'h1B, "");
    step(3'd5, 32'h7, 32'h1C, "");
    step(3'd6, 32'h0, 32'h1D, "R7");
    // R4: stepped load wrap
    step(3'd7, 32'hFFFF_FFFF, 32'h1E, "");
    step(3'd2, 32'h0, 32'h1F, "");
    step(3'd6, 32'h0, 32'h20, "R4");
    step(3'd1, 32'h0, 32'h21, "");
    // R2: set-pointer and idle do not write
    step(3'd0, 32'hDEAD_BEEF, 32'h22, "");
    step(3'd7, 32'd5, 32'h23, "");
    step(3'd1, 32'h0, 32'h24, "");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule